// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small memory-mapped mailbox placed between a host processor and an embedded system controller. The host sees a 32-bit word register bus. Through it the host loads a 16-byte outgoing data buffer and two pointer registers, then writes a command word. Accepting a command sets a busy flag and raises a single-cycle doorbell toward the controller. The controller reads the command, the pointers and the outgoing buffer, and can fill a 16-byte reply buffer. It then reports completion with a done pulse that carries an error flag and an 8-bit error code.

The host polls the status word until busy clears, reads the error fields, and then collects the reply words. If the command asked for it, completion also gives the host a one-cycle interrupt pulse that needs no clearing. A command written while the previous one is still running is dropped. The controller sees this as a sticky overrun flag.

Top module: `mbox_regblk`

## Requirements
- R1: After reset the status word reads busy=0, error=0, command id=0 and error code=0, with the initiator id parameter in bits [15:8]. `ctl_doorbell`, `host_irq` and `ctl_overrun` are low, and read data is zero.
- R2: A host write to offset 0x00 while idle is accepted at that clock edge. From the next cycle status bit 0 (busy) reads 1, `ctl_cmd_word` holds the written word, and status bits [7:4] hold command-word bits [15:12]. `ctl_doorbell` is high for exactly the one cycle after the accepting edge.
- R3: A `ctl_done` pulse while busy clears busy. In the same edge it loads status bit 1 from `ctl_done_err` and status bits [23:16] from `ctl_done_code`. Accepting a new command clears both error fields.
- R4: If bit 8 of the accepted command word is 1, `host_irq` is high for exactly the one cycle after the completing edge. If bit 8 is 0, `host_irq` stays low.
- R5: A command write while busy is ignored: `ctl_cmd_word` and the status word stay unchanged and no doorbell follows. `ctl_overrun` goes to 1 and stays 1 until reset.
- R6: A `ctl_done` pulse while not busy changes nothing in the status word and gives no `host_irq`.
- R7: Writes to 0x08 and 0x0C appear on `ctl_src_ptr` and `ctl_dst_ptr`. Host reads of the write-only offsets 0x00, 0x08, 0x0C and 0x80–0x8F return zero.
- R8: A host write to 0x80+4k stores word k of the outgoing buffer, and `ctl_wbuf_rdata` shows that word when `ctl_wbuf_idx`=k.
- R9: A controller write of word k (`ctl_rbuf_we`, `ctl_rbuf_idx`) is returned by a host read of 0x90+4k. Host writes to 0x90–0x9F are ignored. `hst_rdata` updates at the edge where `hst_rd_en` is high and holds its value otherwise.
- R10: `ctl_byte_valid[i]` is 1 exactly when i is below the size field (bits [23:16]) of the current command word. Sizes of 16 and above mark all bytes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read strobe |
| hst_addr | input | 8 | Host byte address (word aligned) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Completion pulse to host |
| ctl_doorbell | output | 1 | New-command pulse to controller |
| ctl_cmd_word | output | 32 | Last accepted command word |
| ctl_src_ptr | output | 32 | Source pointer |
| ctl_dst_ptr | output | 32 | Destination pointer |
| ctl_byte_valid | output | 16 | Per-byte valid mask of outgoing buffer |
| ctl_wbuf_idx | input | 2 | Outgoing buffer word select |
| ctl_wbuf_rdata | output | 32 | Selected outgoing buffer word |
| ctl_rbuf_we | input | 1 | Reply buffer write strobe |
| ctl_rbuf_idx | input | 2 | Reply buffer word select |
| ctl_rbuf_wdata | input | 32 | Reply buffer write data |
| ctl_done | input | 1 | Completion pulse |
| ctl_done_err | input | 1 | Error flag with completion |
| ctl_done_code | input | 8 | Error code with completion |
| ctl_overrun | output | 1 | Sticky dropped-command flag |

## Verification
The bench writes a second command while the first is still running. A design that accepted it would change the latched command and ring the doorbell again, and one that lost the overrun flag would clear it after the next good command. It sends done pulses while idle, which a careless design would take as a fresh error report or an extra host interrupt. It issues commands with and without the completion-interrupt bit, so an interrupt tied to every completion shows up. It also sweeps the size field across zero, a partial value, exactly sixteen and an oversized value, where an off-by-one or a wrapping compare gives the wrong valid mask.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DST  = 8'h0C;
  localparam logic [3:0]        PAGE_WBUF = 4'h8;
  localparam logic [3:0]        PAGE_RBUF = 4'h9;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] id;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] opcode;
  } cmd_word_t;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] code;
    logic [7:0] initiator;
    logic [3:0] id;
    logic [1:0] rsv_lo;
    logic       err;
    logic       busy;
  } stat_word_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_cmd_ctrl.sv
module mbox_cmd_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              done,
  input  logic              done_err,
  input  logic [7:0]        done_code,
  output logic              busy,
  output logic              err,
  output logic [7:0]        err_code,
  output logic [WORD_W-1:0] cmd_word,
  output logic              doorbell,
  output logic              irq,
  output logic              overrun
);
  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic [7:0]        code_q, code_d;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic              bell_q, bell_d;
  logic              irq_q, irq_d;
  logic              ovr_q, ovr_d;
  logic              accept, finish;
  cmd_word_t         cmd_view;

  assign cmd_view = cmd_word_t'(cmd_q);
  assign accept   = cmd_wr && !busy_q;
  assign finish   = done && busy_q;

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    code_d = code_q;
    cmd_d  = cmd_q;
    ovr_d  = ovr_q;
    bell_d = accept;
    irq_d  = finish && cmd_view.ioc;
    if (accept) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
      code_d = '0;
      cmd_d  = cmd_wdata;
    end else if (finish) begin
      busy_d = 1'b0;
      err_d  = done_err;
      code_d = done_code;
    end
    if (cmd_wr && busy_q) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      cmd_q  <= '0;
      bell_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      code_q <= code_d;
      cmd_q  <= cmd_d;
      bell_q <= bell_d;
      irq_q  <= irq_d;
      ovr_q  <= ovr_d;
    end
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign err_code = code_q;
  assign cmd_word = cmd_q;
  assign doorbell = bell_q;
  assign irq      = irq_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WIDTH  = 32,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic             ld;
    logic [WIDTH-1:0] nxt;
    assign ld  = wr_en && (wr_idx == IDX_W'(w));
    assign nxt = ld ? wr_data : mem_q[w];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[w] <= '0;
      else        mem_q[w] <= nxt;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/mbox_size_decode.sv
module mbox_size_decode #(
  parameter int unsigned BYTES  = 16,
  parameter int unsigned SIZE_W = 8
) (
  input  logic [SIZE_W-1:0] size,
  output logic [BYTES-1:0]  valid
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign valid[b] = (SIZE_W'(b) < size);
  end
endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
  import mbox_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  parameter logic [7:0]  INIT_ID   = 8'h01,
  localparam int unsigned BUF_WORDS = BUF_BYTES / 4,
  localparam int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic              hst_rd_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  output logic              host_irq,
  output logic              ctl_doorbell,
  output logic [WORD_W-1:0] ctl_cmd_word,
  output logic [WORD_W-1:0] ctl_src_ptr,
  output logic [WORD_W-1:0] ctl_dst_ptr,
  output logic [BUF_BYTES-1:0] ctl_byte_valid,
  input  logic [IDX_W-1:0]  ctl_wbuf_idx,
  output logic [WORD_W-1:0] ctl_wbuf_rdata,
  input  logic              ctl_rbuf_we,
  input  logic [IDX_W-1:0]  ctl_rbuf_idx,
  input  logic [WORD_W-1:0] ctl_rbuf_wdata,
  input  logic              ctl_done,
  input  logic              ctl_done_err,
  input  logic [7:0]        ctl_done_code,
  output logic              ctl_overrun
);
  logic              rst_n_i;
  logic              cmd_wr, src_wr, dst_wr, wbuf_wr;
  logic              busy, err;
  logic [7:0]        err_code;
  logic [IDX_W-1:0]  hst_idx;
  logic [WORD_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [WORD_W-1:0] rbuf_host_word, wbuf_unused;
  logic [WORD_W-1:0] rd_mux, rdata_q, rdata_d;
  stat_word_t        stat;
  cmd_word_t         cmd_view;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign hst_idx = hst_addr[IDX_W+1:2];
  assign cmd_wr  = hst_wr_en && (hst_addr == OFS_CMD);
  assign src_wr  = hst_wr_en && (hst_addr == OFS_SRC);
  assign dst_wr  = hst_wr_en && (hst_addr == OFS_DST);
  assign wbuf_wr = hst_wr_en && (hst_addr[7:4] == PAGE_WBUF);

  mbox_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_wr(cmd_wr), .cmd_wdata(hst_wdata),
    .done(ctl_done), .done_err(ctl_done_err), .done_code(ctl_done_code),
    .busy(busy), .err(err), .err_code(err_code),
    .cmd_word(ctl_cmd_word), .doorbell(ctl_doorbell),
    .irq(host_irq), .overrun(ctl_overrun)
  );

  mbox_wordbuf #(.WORDS(BUF_WORDS), .WIDTH(WORD_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(wbuf_wr), .wr_idx(hst_idx), .wr_data(hst_wdata),
    .rd_idx(ctl_wbuf_idx), .rd_data(ctl_wbuf_rdata)
  );

  mbox_wordbuf #(.WORDS(BUF_WORDS), .WIDTH(WORD_W)) u_rbuf (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(ctl_rbuf_we), .wr_idx(ctl_rbuf_idx), .wr_data(ctl_rbuf_wdata),
    .rd_idx(hst_idx), .rd_data(rbuf_host_word)
  );

  assign cmd_view = cmd_word_t'(ctl_cmd_word);

  mbox_size_decode #(.BYTES(BUF_BYTES), .SIZE_W(8)) u_size (
    .size(cmd_view.size), .valid(ctl_byte_valid)
  );

  assign wbuf_unused = '0;

  always_comb begin
    stat           = '0;
    stat.busy      = busy;
    stat.err       = err;
    stat.id        = cmd_view.id;
    stat.initiator = INIT_ID;
    stat.code      = err_code;
  end

  always_comb begin
    src_d = src_wr ? hst_wdata : src_q;
    dst_d = dst_wr ? hst_wdata : dst_q;
  end

  always_comb begin
    if (hst_addr == OFS_STAT)               rd_mux = WORD_W'(stat);
    else if (hst_addr[7:4] == PAGE_RBUF)    rd_mux = rbuf_host_word;
    else                                    rd_mux = wbuf_unused;
    rdata_d = hst_rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q   <= '0;
      dst_q   <= '0;
      rdata_q <= '0;
    end else begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      rdata_q <= rdata_d;
    end
  end

  assign ctl_src_ptr = src_q;
  assign ctl_dst_ptr = dst_q;
  assign hst_rdata   = rdata_q;
endmodule

// File: rtl/mbox_regblk_chk.sv
module mbox_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        busy,
  input logic        ctl_done,
  input logic        ctl_doorbell,
  input logic        host_irq,
  input logic        ctl_overrun,
  input logic [31:0] ctl_cmd_word
);
  // R2
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (busy && ctl_doorbell));
  // R2
  doorbell_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_doorbell |=> !ctl_doorbell);
  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_done) |=> !busy);
  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(busy && ctl_done));
  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && !ctl_done) |=> ($stable(ctl_cmd_word) && !ctl_doorbell));
  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_overrun |=> ctl_overrun);
  // R6
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_done && !cmd_wr) |=> !busy);
endmodule

bind mbox_regblk mbox_regblk_chk u_chk (
  .clk(clk), .rst_n(rst_n_i), .cmd_wr(cmd_wr), .busy(busy),
  .ctl_done(ctl_done), .ctl_doorbell(ctl_doorbell), .host_irq(host_irq),
  .ctl_overrun(ctl_overrun), .ctl_cmd_word(ctl_cmd_word)
);

// File: tb/mbox_regblk_tb.sv
module mbox_regblk_tb_top;
  logic        clk;
  logic        rst_n;
  logic        hst_wr_en, hst_rd_en;
  logic [7:0]  hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic        host_irq, ctl_doorbell, ctl_overrun;
  logic [31:0] ctl_cmd_word, ctl_src_ptr, ctl_dst_ptr, ctl_wbuf_rdata;
  logic [15:0] ctl_byte_valid;
  logic [1:0]  ctl_wbuf_idx, ctl_rbuf_idx;
  logic        ctl_rbuf_we, ctl_done, ctl_done_err;
  logic [31:0] ctl_rbuf_wdata;
  logic [7:0]  ctl_done_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;

  mbox_regblk dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    hst_rd_en = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_rd_en = 1'b0;
    d = hst_rdata;
  endtask

  task automatic cdone(input logic e, input logic [7:0] c);
    ctl_done = 1'b1; ctl_done_err = e; ctl_done_code = c;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic t_reset;
    hrd(8'h04, rd);
    chk("R1 status", rd, 32'h0000_0100);
    chk("R1 outputs", {29'd0, ctl_doorbell, host_irq, ctl_overrun}, 32'd0);
  endtask

  task automatic t_cmd_ioc;
    hwr(8'h00, 32'h0005_31A7);
    chk("R2 doorbell", {31'd0, ctl_doorbell}, 32'd1);
    chk("R2 cmd word", ctl_cmd_word, 32'h0005_31A7);
    hrd(8'h04, rd);
    chk("R2 doorbell gone", {31'd0, ctl_doorbell}, 32'd0);
    chk("R2 status busy", rd, 32'h0000_0131);
    cdone(1'b1, 8'h5C);
    chk("R4 irq pulse", {31'd0, host_irq}, 32'd1);
    @(negedge clk);
    chk("R4 irq single", {31'd0, host_irq}, 32'd0);
    hrd(8'h04, rd);
    chk("R3 status err", rd, 32'h005C_0132);
  endtask

  task automatic t_no_ioc;
    hwr(8'h00, 32'h0010_7000);
    hrd(8'h04, rd);
    chk("R3 err cleared on accept", rd, 32'h0000_0171);
    cdone(1'b0, 8'h33);
    chk("R4 no irq", {31'd0, host_irq}, 32'd0);
    hrd(8'h04, rd);
    chk("R3 status ok", rd, 32'h0033_0170);
  endtask

  task automatic t_overrun;
    hwr(8'h00, 32'h0000_2101);
    chk("R5 overrun clear", {31'd0, ctl_overrun}, 32'd0);
    @(negedge clk);
    hwr(8'h00, 32'h0000_9155);
    chk("R5 no doorbell", {31'd0, ctl_doorbell}, 32'd0);
    chk("R5 cmd kept", ctl_cmd_word, 32'h0000_2101);
    chk("R5 overrun set", {31'd0, ctl_overrun}, 32'd1);
    hrd(8'h04, rd);
    chk("R5 status kept", rd, 32'h0000_0121);
    cdone(1'b0, 8'h00);
    @(negedge clk);
    hwr(8'h00, 32'h0000_4002);
    chk("R5 overrun sticky", {31'd0, ctl_overrun}, 32'd1);
    cdone(1'b0, 8'h00);
  endtask

  task automatic t_idle_done;
    @(negedge clk);
    cdone(1'b1, 8'hEE);
    chk("R6 no irq", {31'd0, host_irq}, 32'd0);
    hrd(8'h04, rd);
    chk("R6 status unchanged", rd, 32'h0000_0140);
  endtask

  task automatic t_ptr_wbuf;
    hwr(8'h08, 32'hDEAD_0008);
    hwr(8'h0C, 32'hBEEF_000C);
    chk("R7 src", ctl_src_ptr, 32'hDEAD_0008);
    chk("R7 dst", ctl_dst_ptr, 32'hBEEF_000C);
    for (int k = 0; k < 4; k++) hwr(8'h80 + 8'(4*k), 32'hA000_0000 + 32'(k));
    for (int k = 0; k < 4; k++) begin
      ctl_wbuf_idx = 2'(k);
      #1;
      chk("R8 wbuf word", ctl_wbuf_rdata, 32'hA000_0000 + 32'(k));
    end
    hrd(8'h08, rd); chk("R7 src reads zero", rd, 32'd0);
    hrd(8'h0C, rd); chk("R7 dst reads zero", rd, 32'd0);
    hrd(8'h00, rd); chk("R7 cmd reads zero", rd, 32'd0);
    hrd(8'h84, rd); chk("R7 wbuf reads zero", rd, 32'd0);
  endtask

  task automatic t_rbuf;
    for (int k = 0; k < 4; k++) begin
      ctl_rbuf_we = 1'b1; ctl_rbuf_idx = 2'(k); ctl_rbuf_wdata = 32'h5500_0000 + 32'(k * 3);
      @(negedge clk);
    end
    ctl_rbuf_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      hrd(8'h90 + 8'(4*k), rd);
      chk("R9 rbuf word", rd, 32'h5500_0000 + 32'(k * 3));
    end
    hwr(8'h98, 32'h1234_5678);
    hrd(8'h98, rd);
    chk("R9 host write ignored", rd, 32'h5500_0006);
    @(negedge clk);
    chk("R9 rdata held", hst_rdata, 32'h5500_0006);
  endtask

  task automatic t_size(input logic [7:0] sz, input logic [15:0] exp);
    hwr(8'h00, {8'h00, sz, 16'h0011});
    chk("R10 byte valid", {16'd0, ctl_byte_valid}, {16'd0, exp});
    cdone(1'b0, 8'h00);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hst_wr_en = 1'b0; hst_rd_en = 1'b0; hst_addr = '0; hst_wdata = '0;
    ctl_wbuf_idx = '0; ctl_rbuf_idx = '0; ctl_rbuf_we = 1'b0; ctl_rbuf_wdata = '0;
    ctl_done = 1'b0; ctl_done_err = 1'b0; ctl_done_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata zero", hst_rdata, 32'd0);
    t_reset();
    t_cmd_ioc();
    t_no_ioc();
    t_overrun();
    t_idle_done();
    t_ptr_wbuf();
    t_rbuf();
    t_size(8'd0,   16'h0000);
    t_size(8'd5,   16'h001F);
    t_size(8'd16,  16'hFFFF);
    t_size(8'd200, 16'hFFFF);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule